// File: doc/BRIEF.md
# Single-Entry Activation Sampler for Refresh-Time Row Mitigation

This block watches the stream of row activations going to one DRAM bank and picks exactly one of them per refresh interval as the row to protect. At every mitigation point (a periodic refresh or an extra refresh-management command) it draws a pseudo-random ordinal from an internal LFSR. It then counts activations in the interval that follows and keeps the row address of the activation whose ordinal equals the draw.

At the next mitigation point it reports the kept row through a one-cycle valid pulse, so that victim-refresh logic outside the block can act on it. The block then starts the next interval with a fresh draw. Only one row can be handled per refresh, so one entry is the whole state. Refreshes may be postponed: the activation counter saturates, and a row already kept stays held until a mitigation point finally arrives.

Top module: `rh_single_tracker`

## Requirements
- R1: While rst_ni is low and after it is released, mit_valid_o is 0 and mit_row_o is 0 until the first mitigation point with a kept row.
- R2: The LFSR is 16-bit, Galois, right-shifting, with XOR mask 0xB400 applied when the shifted-out bit is 1, and loads SEED (default 0xACE1) on reset. The index for an interval is (state mod MAX_ACT)+1, taken from the state after reset for the first interval. The state advances exactly once at each mitigation point.
- R3: Within an interval, the activation whose ordinal (counting from 1) equals the index has its row kept. Later activations in that interval do not replace it.
- R4: When ref_i is high in a cycle and a row is kept, mit_valid_o is high in the next cycle and mit_row_o equals the kept row.
- R5: If an interval ends with fewer activations than its index, mit_valid_o stays low after the mitigation point and mit_row_o keeps its previous value.
- R6: rfm_i acts as a mitigation point in exactly the same way as ref_i.
- R7: Every mitigation point clears the activation count and installs a new index before the next interval's activations are counted.
- R8: An activation in the same cycle as a mitigation point is ordinal 1 of the new interval, and it is kept if the new index is 1.
- R9: With postponed refresh, the count saturates at MAX_ACT. An activation beyond MAX_ACT in an interval is never kept, and the kept row survives until the next mitigation point.
- R10: mit_valid_o is high only in the cycle after a mitigation point, and mit_row_o changes only in that cycle.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Row activation strobe |
| act_row_i | input | ROW_W | Row address of the activation |
| ref_i | input | 1 | Periodic refresh strobe (mitigation point) |
| rfm_i | input | 1 | Extra refresh-management strobe (mitigation point) |
| mit_valid_o | output | 1 | One-cycle pulse: a row is offered for mitigation |
| mit_row_o | output | ROW_W | Row offered for mitigation |

## Verification
The assertions assume that the strobes are clean single-cycle levels sampled at the clock edge. They also assume that ref_i and rfm_i may coincide with each other and with act_i, and that they are treated as one mitigation point. The stimulus drives all inputs on the falling edge. It sweeps interval lengths from zero up to beyond MAX_ACT, alternates refresh and RFM endings, and sometimes places an activation in the mitigation cycle itself. The bench reproduces the index sequence from the LFSR equation given in R2.

// File: rtl/rht_pkg.sv
package rht_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    lfsr_step = s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction
endpackage

// File: rtl/rht_draw.sv
module rht_draw
  import rht_pkg::*;
#(
  parameter int unsigned MAX_ACT = 64,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  localparam int unsigned CNT_W = $clog2(MAX_ACT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             point_i,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] idx_nxt_o
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;

  assign lfsr_nxt = lfsr_step(lfsr_q);

  function automatic logic [CNT_W-1:0] to_idx(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] m;
    m = s % LFSR_W'(MAX_ACT);
    to_idx = CNT_W'(m) + CNT_W'(1);
  endfunction

  assign idx_o     = to_idx(lfsr_q);
  assign idx_nxt_o = to_idx(lfsr_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lfsr_q <= SEED;
    else if (point_i) lfsr_q <= lfsr_nxt;
  end
endmodule

// File: rtl/rht_window.sv
module rht_window #(
  parameter int unsigned MAX_ACT = 64,
  parameter int unsigned ROW_W   = 16,
  localparam int unsigned CNT_W  = $clog2(MAX_ACT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             point_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [CNT_W-1:0] idx_nxt_i,
  output logic             hit_o,
  output logic [ROW_W-1:0] row_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ACT);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             hit_q;
  logic [ROW_W-1:0] row_q;
  logic             can_inc;

  assign can_inc = (cnt_q != CNT_MAX);
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
      row_q <= '0;
    end else if (point_i) begin
      // same-cycle ACT opens the new interval as ordinal 1
      cnt_q <= act_i ? CNT_W'(1) : '0;
      hit_q <= act_i && (idx_nxt_i == CNT_W'(1));
      if (act_i && (idx_nxt_i == CNT_W'(1))) row_q <= act_row_i;
    end else if (act_i && can_inc) begin
      cnt_q <= cnt_inc;
      if (cnt_inc == idx_i) begin
        hit_q <= 1'b1;
        row_q <= act_row_i;
      end
    end
  end

  assign hit_o = hit_q;
  assign row_o = row_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rht_mit_out.sv
module rht_mit_out #(
  parameter int unsigned ROW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             point_i,
  input  logic             hit_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             valid_o,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      row_o   <= '0;
    end else begin
      valid_o <= point_i && hit_i;
      if (point_i && hit_i) row_o <= row_i;
    end
  end
endmodule

// File: rtl/rh_single_tracker.sv
module rh_single_tracker
  import rht_pkg::*;
#(
  parameter int unsigned MAX_ACT = 64,
  parameter int unsigned ROW_W   = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             ref_i,
  input  logic             rfm_i,
  output logic             mit_valid_o,
  output logic [ROW_W-1:0] mit_row_o
);
  localparam int unsigned CNT_W = $clog2(MAX_ACT + 1);

  logic             point;
  logic [CNT_W-1:0] idx, idx_nxt, act_cnt;
  logic             hit;
  logic [ROW_W-1:0] trk_row;

  assign point = ref_i | rfm_i;

  rht_draw #(.MAX_ACT(MAX_ACT), .SEED(SEED)) u_draw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .point_i  (point),
    .idx_o    (idx),
    .idx_nxt_o(idx_nxt)
  );

  rht_window #(.MAX_ACT(MAX_ACT), .ROW_W(ROW_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act_i),
    .act_row_i(act_row_i),
    .point_i  (point),
    .idx_i    (idx),
    .idx_nxt_i(idx_nxt),
    .hit_o    (hit),
    .row_o    (trk_row),
    .cnt_o    (act_cnt)
  );

  rht_mit_out #(.ROW_W(ROW_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .point_i(point),
    .hit_i  (hit),
    .row_i  (trk_row),
    .valid_o(mit_valid_o),
    .row_o  (mit_row_o)
  );
endmodule

// File: rtl/rht_chk.sv
module rht_chk #(
  parameter int unsigned MAX_ACT = 64,
  parameter int unsigned ROW_W   = 16,
  localparam int unsigned CNT_W  = $clog2(MAX_ACT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             act_i,
  input logic             ref_i,
  input logic             rfm_i,
  input logic             mit_valid_o,
  input logic [ROW_W-1:0] mit_row_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] idx_i
);
  p_valid_after_point_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mit_valid_o |-> $past(ref_i || rfm_i));

  p_row_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_i || rfm_i) |-> $stable(mit_row_o));

  p_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mit_valid_o |=> (!mit_valid_o || $past(ref_i || rfm_i)));

  p_cnt_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i || rfm_i) |=> (cnt_i == {{(CNT_W-1){1'b0}}, $past(act_i)}));

  p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(MAX_ACT));

  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i >= CNT_W'(1)) && (idx_i <= CNT_W'(MAX_ACT)));
endmodule

bind rh_single_tracker rht_chk #(.MAX_ACT(MAX_ACT), .ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_i      (act_i),
  .ref_i      (ref_i),
  .rfm_i      (rfm_i),
  .mit_valid_o(mit_valid_o),
  .mit_row_o  (mit_row_o),
  .cnt_i      (act_cnt),
  .idx_i      (idx)
);

// File: tb/tb_rh_single_tracker.sv
module tb_rh_single_tracker;
  localparam int N  = 4;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          act_i = 1'b0, ref_i = 1'b0, rfm_i = 1'b0;
  logic [RW-1:0] act_row_i = '0;
  logic          mit_valid_o;
  logic [RW-1:0] mit_row_o;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  rh_single_tracker #(.MAX_ACT(N), .ROW_W(RW), .SEED(16'hACE1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .act_i(act_i), .act_row_i(act_row_i),
    .ref_i(ref_i), .rfm_i(rfm_i), .mit_valid_o(mit_valid_o), .mit_row_o(mit_row_o)
  );

  // reference state from the requirement equations
  logic [15:0]   m_lfsr;
  int            m_idx, m_cnt;
  bit            m_hit;
  logic [RW-1:0] m_trow, e_row;
  bit            e_valid;

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  task automatic chk(input string tag, input logic [RW-1:0] act_v, input logic [RW-1:0] exp_v,
                     input string what);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic step(input bit a, input logic [RW-1:0] r, input bit f, input bit m,
                      input string tag);
    act_i = a; act_row_i = r; ref_i = f; rfm_i = m;
    @(posedge clk);
    e_valid = 1'b0;
    if (f || m) begin
      e_valid = m_hit;
      if (m_hit) e_row = m_trow;
      m_lfsr = nxt(m_lfsr);
      m_idx  = int'(m_lfsr % 16'(N)) + 1;
      m_cnt  = a ? 1 : 0;
      m_hit  = a && (m_idx == 1);
      if (m_hit) m_trow = r;
    end else if (a && m_cnt < N) begin
      m_cnt++;
      if (m_cnt == m_idx) begin
        m_hit = 1'b1;
        m_trow = r;
      end
    end
    @(negedge clk);
    act_i = 1'b0; ref_i = 1'b0; rfm_i = 1'b0;
    chk(tag, RW'(mit_valid_o), RW'(e_valid), "valid");
    chk(tag, mit_row_o, e_row, "row");
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_lfsr = 16'hACE1;
    m_idx  = int'(m_lfsr % 16'(N)) + 1;
    m_cnt = 0; m_hit = 1'b0; m_trow = '0; e_row = '0; e_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", RW'(mit_valid_o), '0, "valid in reset");
    chk("R1", mit_row_o, '0, "row in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", RW'(mit_valid_o), '0, "valid after reset");
    // first interval: exactly idx ACTs then refresh (R2 seed index, R3 latch)
    for (int j = 0; j < m_idx; j++) step(1'b1, RW'(8'hA0 + j), 1'b0, 1'b0, "R2/R3");
    step(1'b0, '0, 1'b1, 1'b0, "R2/R4");
    // sweep interval lengths, endings and same-cycle ACTs
    for (int rep = 0; rep < 24; rep++) begin
      for (int k = 0; k <= N + 3; k++) begin
        string tag;
        bit    use_rfm, co_act;
        use_rfm = ((rep + k) % 2) == 1;
        co_act  = (rep % 3) == 0;
        if (k == 0)      tag = "R5";
        else if (k > N)  tag = "R9";
        else if (co_act) tag = "R8";
        else if (use_rfm) tag = "R6";
        else             tag = "R4/R3";
        for (int j = 0; j < k; j++) begin
          step(1'b1, RW'(rep * 16 + k * 2 + j), 1'b0, 1'b0, "R3/R10");
          if ((j % 2) == 1) step(1'b0, '0, 1'b0, 1'b0, "R10");
        end
        if (rep == 7) repeat (3) step(1'b0, '0, 1'b0, 1'b0, "R9");
        step(co_act, RW'(8'hF0 + k), !use_rfm || (rep == 5), use_rfm, tag);
        step(1'b0, '0, 1'b0, 1'b0, "R7/R10");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule